// File: doc/BRIEF.md
# Gated Wheel Pulse-Rate Meter with RPM Output

This block measures how fast a wheel turns. A magnetic sensor produces one pulse for each revolution. The block brings that signal into its clock domain and counts its rising edges. It counts only inside a measurement window, and a reloadable down-counter sets the length of that window. When a window closes, the block publishes the count it gathered and raises a one-cycle update strobe. It then starts a new window at once, so no cycle falls between two windows.

Beside the raw count, the block gives the count multiplied by sixty. It forms this value with two shifts and one subtraction, so it needs neither a divider nor a multiplier. If the window lasts exactly one second, this value is the speed in revolutions per minute. The whole design runs on one clock and one synchronous reset. The sensor input is sampled only by flops and never acts as a reset or a clock.

Top module: `pulse_rate_meter`

## Requirements
- R1: While `rst` is high at a clock edge, `pulse_count`, `rpm` and `update` become zero, the running edge count clears, and the window timer loads `gate_preset`.
- R2: The window timer decrements once per clock. In the cycle where it holds zero, the window closes and the timer reloads `gate_preset`. Windows therefore last `gate_preset`+1 cycles, and `update` is high for one cycle after each close.
- R3: At a window close, the running edge count is copied to `pulse_count`. The copy is visible in the cycle where `update` is high.
- R4: `hall_i` passes through a two-flop synchronizer. Each low-to-high change between consecutive synchronized samples adds exactly one to the running count. A level sampled at edge k is counted at edge k+2.
- R5: If a counted edge falls on the same clock edge that closes a window, the old window's total does not include it, and the new window starts at one instead of zero.
- R6: The running count saturates at its all-ones value (255 for an 8-bit counter) and does not wrap.
- R7: `rpm` always equals 60 times `pulse_count`, and it is updated in the same cycle.
- R8: In any cycle where `update` is low, `pulse_count` and `rpm` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_i | input | 1 | Raw sensor level, one pulse per revolution |
| gate_preset | input | TMR_W | Window length minus one, in cycles |
| pulse_count | output | CNT_W | Edge count of the last completed window |
| rpm | output | CNT_W+6 | `pulse_count` times 60 |
| update | output | 1 | One-cycle strobe when new values are published |

## Verification
The assertions assume that `gate_preset` is nonzero and changes only while `rst` is high. Under that assumption the update strobe can never stay high for two cycles in a row. They also assume that reset is held for several cycles before the checks start. The stimulus follows both assumptions: it loads each new window length inside a reset phase. The sensor level is then driven with random or toggling values, each held for at least one full cycle, so every high level is seen by the synchronizer.

// File: rtl/prm_pkg.sv
package prm_pkg;
    localparam int PRM_SYNC_STAGES = 2;
    localparam int PRM_RPM_HI      = 6;  // 64x term
    localparam int PRM_RPM_LO      = 2;  // 4x term
    localparam int PRM_RPM_EXTRA   = 6;  // headroom bits for 60x
endpackage

// File: rtl/prm_edge_sync.sv
module prm_edge_sync #(
    parameter int STAGES = prm_pkg::PRM_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic hall_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CHAIN_W-2:0], hall_i};
        if (rst) begin
            s_d.chain = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // newest synchronized sample high, the one before it low
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
endmodule

// File: rtl/prm_gate_timer.sv
module prm_gate_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] preset_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [TMR_W-1:0] remain;
    } tmr_t;

    tmr_t t_d, t_q;
    logic at_zero;

    assign at_zero = (t_q.remain == '0);

    always_comb begin
        t_d = t_q;
        if (rst || at_zero) begin
            t_d.remain = preset_i;
        end else begin
            t_d.remain = t_q.remain - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign tick_o = at_zero & ~rst;
endmodule

// File: rtl/prm_pulse_counter.sv
module prm_pulse_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] live_o,
    output logic [CNT_W-1:0] pub_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] pub;
        logic             upd;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.upd = 1'b0;
        if (rst) begin
            c_d = '0;
        end else if (tick_i) begin
            c_d.pub  = c_q.live;
            c_d.upd  = 1'b1;
            c_d.live = rise_i ? CNT_W'(1) : '0;
        end else if (rise_i && (c_q.live != CNT_MAX)) begin
            c_d.live = c_q.live + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign live_o = c_q.live;
    assign pub_o  = c_q.pub;
    assign upd_o  = c_q.upd;
endmodule

// File: rtl/prm_rpm_scale.sv
module prm_rpm_scale #(
    parameter int CNT_W  = 16,
    parameter int RPM_W  = CNT_W + prm_pkg::PRM_RPM_EXTRA,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [RPM_W-1:0] rpm_o
);
    generate
        if (ENABLE) begin : g_scale
            typedef struct packed {
                logic [RPM_W-1:0] rpm;
            } rpm_t;

            rpm_t r_d, r_q;
            logic [RPM_W-1:0] wide;
            logic [RPM_W-1:0] times60;

            assign wide    = RPM_W'(cnt_i);
            assign times60 = (wide << prm_pkg::PRM_RPM_HI) - (wide << prm_pkg::PRM_RPM_LO);

            always_comb begin
                r_d = r_q;
                if (rst) begin
                    r_d.rpm = '0;
                end else if (tick_i) begin
                    r_d.rpm = times60;
                end
            end

            always_ff @(posedge clk) begin
                r_q <= r_d;
            end

            assign rpm_o = r_q.rpm;
        end else begin : g_bypass
            assign rpm_o = '0;
        end
    endgenerate
endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
    parameter int CNT_W       = 16,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = prm_pkg::PRM_SYNC_STAGES,
    parameter bit RPM_EN      = 1'b1,
    localparam int RPM_W      = CNT_W + prm_pkg::PRM_RPM_EXTRA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hall_i,
    input  logic [TMR_W-1:0] gate_preset,
    output logic [CNT_W-1:0] pulse_count,
    output logic [RPM_W-1:0] rpm,
    output logic             update
);
    logic             hall_rise;
    logic             gate_tick;
    logic [CNT_W-1:0] pulse_cnt;

    prm_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .hall_i (hall_i),
        .rise_o (hall_rise)
    );

    prm_gate_timer #(.TMR_W(TMR_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .preset_i (gate_preset),
        .tick_o   (gate_tick)
    );

    prm_pulse_counter #(.CNT_W(CNT_W)) i_count (
        .clk    (clk),
        .rst    (rst),
        .rise_i (hall_rise),
        .tick_i (gate_tick),
        .live_o (pulse_cnt),
        .pub_o  (pulse_count),
        .upd_o  (update)
    );

    prm_rpm_scale #(.CNT_W(CNT_W), .RPM_W(RPM_W), .ENABLE(RPM_EN)) i_scale (
        .clk    (clk),
        .rst    (rst),
        .tick_i (gate_tick),
        .cnt_i  (pulse_cnt),
        .rpm_o  (rpm)
    );
endmodule

// File: rtl/prm_checker.sv
module prm_checker #(
    parameter int CNT_W = 16,
    parameter int TMR_W = 16,
    localparam int RPM_W = CNT_W + prm_pkg::PRM_RPM_EXTRA
) (
    input logic             clk,
    input logic             rst,
    input logic [TMR_W-1:0] gate_preset,
    input logic [CNT_W-1:0] pulse_count,
    input logic [RPM_W-1:0] rpm,
    input logic             update,
    input logic [CNT_W-1:0] pulse_cnt,
    input logic             gate_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [RPM_W-1:0] SIXTY = RPM_W'(60);

    a_r2_close_gives_update: assert property (@(posedge clk) disable iff (rst)
        gate_tick |=> update);

    a_r3_update_single: assert property (@(posedge clk) disable iff (rst)
        (update && gate_preset != '0) |=> !update);

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (pulse_cnt == CNT_MAX && !gate_tick) |=> pulse_cnt == CNT_MAX);

    a_r7_rpm_scaled: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (rpm == RPM_W'(pulse_count) * SIXTY));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !update |-> ($stable(pulse_count) && $stable(rpm)));
endmodule

bind pulse_rate_meter prm_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_prm_checker (
    .clk         (clk),
    .rst         (rst),
    .gate_preset (gate_preset),
    .pulse_count (pulse_count),
    .rpm         (rpm),
    .update      (update),
    .pulse_cnt   (pulse_cnt),
    .gate_tick   (gate_tick)
);

// File: tb/test_pulse_rate_meter.sv
module test_pulse_rate_meter;
    localparam int CW = 8;
    localparam int TW = 16;
    localparam int RW = CW + 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hall = 1'b0;
    logic [TW-1:0] preset = 16'd5;
    logic [CW-1:0] count_w;
    logic [RW-1:0] rpm_w;
    logic          upd_w;

    int    checks = 0;
    int    fails  = 0;
    string ptag   = "R4";

    // expected-behaviour model state
    bit m_s1, m_s2, m_s3;
    int m_live, m_tmr, m_pub, m_rpm;
    bit m_upd;

    pulse_rate_meter #(.CNT_W(CW), .TMR_W(TW)) i_pulse_rate_meter (
        .clk         (clk),
        .rst         (rst),
        .hall_i      (hall),
        .gate_preset (preset),
        .pulse_count (count_w),
        .rpm         (rpm_w),
        .update      (upd_w)
    );

    always #5 clk = ~clk;

    function automatic int times60(int c);
        return c * 60;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit rise, close;
        rise  = m_s2 & ~m_s3;
        close = (m_tmr == 0);
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_live = 0; m_pub = 0; m_rpm = 0; m_upd = 0;
            m_tmr = int'(preset);
        end else begin
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = hall;
            if (close) begin
                m_pub  = m_live;
                m_rpm  = times60(m_live);
                m_upd  = 1;
                m_live = rise ? 1 : 0;        // R5: coincident edge opens new window
                m_tmr  = int'(preset);
            end else begin
                m_upd = 0;
                if (rise && m_live != CMAX) m_live = m_live + 1;  // R6 saturation
                m_tmr = m_tmr - 1;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst) begin
            chk("R1", int'(count_w), 0);
            chk("R1", int'(rpm_w), 0);
            chk("R1", int'(upd_w), 0);
        end else begin
            chk("R2", int'(upd_w), int'(m_upd));
            if (m_upd) begin
                chk(ptag, int'(count_w), m_pub);
                chk("R7", int'(rpm_w), m_rpm);
            end else begin
                chk("R8", int'(count_w), m_pub);
                chk("R8", int'(rpm_w), m_rpm);
            end
        end
    endtask

    task automatic do_reset(int p);
        rst    = 1'b1;
        hall   = 1'b0;
        preset = TW'(p);
        repeat (4) step();
        rst = 1'b0;
    endtask

    task automatic run_toggle(int n);
        repeat (n) begin
            hall = ~hall;
            step();
        end
    endtask

    task automatic run_rand(int n, int thr);
        repeat (n) begin
            hall = (($urandom % 100) < thr);
            step();
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1 reset state, then R4 basic counting with a short window
        do_reset(3);
        ptag = "R4";
        run_toggle(200);
        run_rand(400, 50);
        // R5: odd window length makes edges alternately land on the close
        do_reset(8);
        ptag = "R5";
        run_toggle(400);
        // R6: 601-cycle window with an edge every two cycles exceeds 255
        do_reset(600);
        ptag = "R6";
        run_toggle(2000);
        // R3 and R4 with random window lengths and pulse densities
        ptag = "R3";
        for (int ph = 0; ph < 8; ph++) begin
            do_reset(5 + int'($urandom % 300));
            run_rand(1500, 10 + int'($urandom % 80));
        end
        // long sensor levels: each revolution holds high for several cycles
        do_reset(40);
        ptag = "R4";
        for (int k = 0; k < 60; k++) begin
            hall = 1'b1;
            repeat (1 + ($urandom % 6)) step();
            hall = 1'b0;
            repeat (1 + ($urandom % 6)) step();
        end
        summary();
        $finish;
    end

    initial begin
        #(2_000_000);
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end
endmodule